// File: doc/BRIEF.md
# Serial Receiver with Break Wake-Up

This block receives asynchronous serial frames on one RX line. A two-flop synchronizer conditions the line. An oversampling tick, supplied from outside, times each bit. Every frame begins with a low start bit, carries 8 or 9 data bits least significant bit first, and ends with one high stop bit. Completed words enter a two-entry receive buffer. The head entry of that buffer drives the data, ninth-bit and framing-error outputs. A one-cycle read strobe removes the head entry. The interrupt output is high whenever unread data is waiting.

The block has a wake-up mode for sleeping systems on a shared bus. The host sets this mode with a one-cycle strobe. While the mode is active, frame reception is suspended and the block watches only for a falling edge on RX. That edge raises the interrupt, and a read strobe lowers it again. The mode turns itself off once RX returns high after the edge, and normal reception then resumes.

Top module: `uart_wake_rx`

## Requirements
- R1: While `rx_en_i` is low, no word is accepted into the buffer and a frame in progress is abandoned.
- R2: In 8-bit mode (`nine_bit_i`=0) a frame is one low start bit, eight data bits LSB first and a stop bit. The data byte appears on `rd_data_o` and `rd_bit8_o` reads 0.
- R3: In 9-bit mode (`nine_bit_i`=1) nine data bits are received. The first eight form `rd_data_o` and the ninth appears on `rd_bit8_o`.
- R4: The buffer holds up to two unread words and presents them in arrival order.
- R5: A word that completes while two unread words are buffered sets `overrun_o` and is discarded. The buffered words are kept. No further word is accepted until `rx_en_i` is driven low, which also clears `overrun_o`.
- R6: `frame_err_o` is 1 for a buffered word whose stop bit was sampled low, and 0 otherwise.
- R7: `rx_irq_o` is 1 whenever the buffer holds unread data. A read strobe removes the head word. After reset the buffer is empty, `rx_irq_o`=0 and `overrun_o`=0.
- R8: A start is detected on a falling edge of the synchronized line. If the line is high again at the middle of the start bit (tick 8), the frame is dropped and the receiver returns to idle.
- R9: While the wake-up mode is active, no frame is received. A falling edge on RX sets `rx_irq_o`, and a read strobe clears it.
- R10: After a wake-up edge, the wake-up mode (`wake_en_o`) clears itself when RX is seen high again, and normal reception resumes.
- R11: Each bit spans 16 baud ticks. Data and stop bits are sampled 16 ticks apart, starting from the middle of the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| rx_en_i | input | 1 | Continuous receive enable; low also clears overrun |
| nine_bit_i | input | 1 | 1 selects 9 data bits per frame |
| wake_set_i | input | 1 | One-cycle strobe that enters wake-up mode |
| rd_i | input | 1 | One-cycle read strobe for the data register |
| rd_data_o | output | 8 | Head word data |
| rd_bit8_o | output | 1 | Head word ninth bit |
| frame_err_o | output | 1 | Head word framing error |
| overrun_o | output | 1 | Overrun flag |
| rx_irq_o | output | 1 | Receive interrupt flag |
| wake_en_o | output | 1 | Wake-up mode active |

## Verification
The embedded assertions check several properties on every cycle. The buffer fill level never exceeds its depth, and overrun rises only on a full buffer. The fill level stays frozen while overrun holds and no read occurs. A disabled receiver falls back to idle, and a high line at mid-start aborts the frame. No word is produced in wake-up mode. A wake edge raises the interrupt, and wake-up mode ends only after the line is seen high. Data correctness needs the bench's scenarios to show it: the bit order, the ninth-bit placement, FIFO order, the discard of the third word, and the interrupt being cleared by a read.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic              bit8;
        logic [DATA_W-1:0] data;
    } rx_word_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_i,
    output logic rx_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], rx_i};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rx_o   = sync_q.chain[STAGES-1];
    assign fall_o = sync_q.prev & ~sync_q.chain[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_wake_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     run_i,
    input  logic     nine_i,
    input  logic     tick_i,
    input  logic     rx_i,
    input  logic     fall_i,
    output logic     word_valid_o,
    output rx_word_t word_o
);

    localparam int SHW = DATA_W + 1;
    localparam int CW  = $clog2(OVS);
    localparam int BW  = $clog2(SHW);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e      state;
        logic [CW-1:0]  cnt;
        logic [BW-1:0]  idx;
        logic [SHW-1:0] shreg;
    } frm_t;

    frm_t frm_d, frm_q;
    logic [BW-1:0] last_idx;

    always_comb begin
        frm_d        = frm_q;
        word_valid_o = 1'b0;
        last_idx     = nine_i ? BW'(SHW - 1) : BW'(SHW - 2);
        word_o.ferr  = ~rx_i;
        word_o.bit8  = nine_i & frm_q.shreg[SHW-1];
        word_o.data  = nine_i ? frm_q.shreg[DATA_W-1:0] : frm_q.shreg[SHW-1:1];

        if (!run_i) begin
            frm_d.state = ST_IDLE;
            frm_d.cnt   = '0;
        end else begin
            unique case (frm_q.state)
                ST_IDLE: begin
                    if (fall_i) begin
                        frm_d.state = ST_START;
                        frm_d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (tick_i) begin
                        if (frm_q.cnt == MID) begin
                            frm_d.cnt = '0;
                            frm_d.idx = '0;
                            frm_d.state = rx_i ? ST_IDLE : ST_DATA;
                        end else begin
                            frm_d.cnt = frm_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick_i) begin
                        if (frm_q.cnt == LAST) begin
                            frm_d.cnt   = '0;
                            frm_d.shreg = {rx_i, frm_q.shreg[SHW-1:1]};
                            if (frm_q.idx == last_idx) begin
                                frm_d.state = ST_STOP;
                            end else begin
                                frm_d.idx = frm_q.idx + 1'b1;
                            end
                        end else begin
                            frm_d.cnt = frm_q.cnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick_i) begin
                        if (frm_q.cnt == LAST) begin
                            word_valid_o = 1'b1;
                            frm_d.state  = ST_IDLE;
                            frm_d.cnt    = '0;
                        end else begin
                            frm_d.cnt = frm_q.cnt + 1'b1;
                        end
                    end
                end
                default: frm_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frm_q <= '{state: ST_IDLE, cnt: '0, idx: '0, shreg: '0};
        end else begin
            frm_q <= frm_d;
        end
    end

    // R1: a disabled receiver is idle one cycle later
    assert_off_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> frm_q.state == ST_IDLE);

    // R8: a high line at mid-start aborts the frame
    assert_glitch_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && frm_q.state == ST_START && tick_i && frm_q.cnt == MID && rx_i)
        |=> frm_q.state == ST_IDLE);

endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
    import uart_wake_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     clr_ovr_i,
    input  logic     push_i,
    input  rx_word_t push_word_i,
    input  logic     pop_i,
    output rx_word_t head_o,
    output logic     empty_o,
    output logic     ovr_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_word_t [DEPTH-1:0] mem;
        logic [AW-1:0]        rd_ptr;
        logic [AW-1:0]        wr_ptr;
        logic [CW-1:0]        cnt;
        logic                 ovr;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  do_pop, do_push, full;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fifo_d  = fifo_q;
        full    = (fifo_q.cnt == CW'(DEPTH));
        do_pop  = pop_i && (fifo_q.cnt != '0);
        do_push = push_i && !fifo_q.ovr && (!full || do_pop);

        if (push_i && !fifo_q.ovr && full && !do_pop) begin
            fifo_d.ovr = 1'b1;
        end
        if (clr_ovr_i) begin
            fifo_d.ovr = 1'b0;
        end
        if (do_push) begin
            fifo_d.mem[fifo_q.wr_ptr] = push_word_i;
            fifo_d.wr_ptr             = wrap_inc(fifo_q.wr_ptr);
        end
        if (do_pop) begin
            fifo_d.rd_ptr = wrap_inc(fifo_q.rd_ptr);
        end
        case ({do_push, do_pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign head_o  = fifo_q.mem[fifo_q.rd_ptr];
    assign empty_o = (fifo_q.cnt == '0);
    assign ovr_o   = fifo_q.ovr;

    // R4: fill level never exceeds the depth
    assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_q.cnt <= CW'(DEPTH));

    // R5: overrun only rises on a full buffer
    assert_ovr_on_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fifo_q.ovr) |-> $past(fifo_q.cnt) == CW'(DEPTH));

    // R5: while overrun holds, nothing is pushed
    assert_ovr_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_q.ovr && !pop_i) |=> $stable(fifo_q.cnt));

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_wake_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_i,
    input  logic              baud_tick_i,
    input  logic              rx_en_i,
    input  logic              nine_bit_i,
    input  logic              wake_set_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_bit8_o,
    output logic              frame_err_o,
    output logic              overrun_o,
    output logic              rx_irq_o,
    output logic              wake_en_o
);

    typedef struct packed {
        logic en;
        logic seen;
        logic irq;
    } wake_t;

    wake_t    wake_d, wake_q;
    logic     rx_s, rx_fall;
    logic     run, word_valid, fifo_empty, fifo_ovr;
    rx_word_t word, head;

    rx_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rx_i   (rx_i),
        .rx_o   (rx_s),
        .fall_o (rx_fall)
    );

    assign run = rx_en_i && !wake_q.en && !fifo_ovr;

    rx_frame_fsm #(
        .OVS (OVS)
    ) u_frame (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (run),
        .nine_i       (nine_bit_i),
        .tick_i       (baud_tick_i),
        .rx_i         (rx_s),
        .fall_i       (rx_fall),
        .word_valid_o (word_valid),
        .word_o       (word)
    );

    rx_word_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_ovr_i   (!rx_en_i),
        .push_i      (word_valid),
        .push_word_i (word),
        .pop_i       (rd_i),
        .head_o      (head),
        .empty_o     (fifo_empty),
        .ovr_o       (fifo_ovr)
    );

    always_comb begin
        wake_d = wake_q;
        if (wake_set_i) begin
            wake_d.en   = 1'b1;
            wake_d.seen = 1'b0;
        end
        if (wake_q.en && rx_fall) begin
            wake_d.seen = 1'b1;
            wake_d.irq  = 1'b1;
        end
        if (wake_q.en && wake_q.seen && rx_s) begin
            wake_d.en   = 1'b0;
            wake_d.seen = 1'b0;
        end
        if (rd_i) begin
            wake_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wake_q <= '0;
        end else begin
            wake_q <= wake_d;
        end
    end

    assign rd_data_o   = head.data;
    assign rd_bit8_o   = head.bit8;
    assign frame_err_o = head.ferr;
    assign overrun_o   = fifo_ovr;
    assign rx_irq_o    = !fifo_empty || wake_q.irq;
    assign wake_en_o   = wake_q.en;

    // R9: no word is produced while wake-up mode is active
    assert_wake_no_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_q.en |-> !word_valid);

    // R9: a wake edge raises the interrupt
    assert_wake_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_q.en && rx_fall && !rd_i) |=> rx_irq_o);

    // R10: wake-up mode ends only after the line is seen high
    assert_wake_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wake_q.en) |-> $past(rx_s));

endmodule

// File: tb/uart_wake_rx_tb_top.sv
`timescale 1ns/1ps
module uart_wake_rx_tb_top;

    localparam int TPB      = 4;          // clocks per baud tick
    localparam int BITCLK   = 16 * TPB;   // clocks per bit

    typedef struct packed {
        logic       ferr;
        logic       bit8;
        logic [7:0] data;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       rx_en = 1'b1;
    logic       nine = 1'b0;
    logic       wake_set = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit8, ferr, ovr, irq, wake_en;
    logic [1:0] tcnt = '0;
    logic       tick;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) tcnt <= tcnt + 2'd1;
    assign tick = (tcnt == 2'(TPB - 1));

    uart_wake_rx dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rx_i        (rx),
        .baud_tick_i (tick),
        .rx_en_i     (rx_en),
        .nine_bit_i  (nine),
        .wake_set_i  (wake_set),
        .rd_i        (rd),
        .rd_data_o   (rd_data),
        .rd_bit8_o   (rd_bit8),
        .frame_err_o (ferr),
        .overrun_o   (ovr),
        .rx_irq_o    (irq),
        .wake_en_o   (wake_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        @(negedge clk);
        rx = v;
        repeat (BITCLK - 1) @(negedge clk);
    endtask

    // driver: sends a frame and pushes the expected word when it will be kept
    task automatic send_frame(input logic [8:0] val, input logic stop,
                              input bit expect_kept);
        exp_t e;
        hold_bit(1'b0);
        for (int i = 0; i < (nine ? 9 : 8); i++) hold_bit(val[i]);
        hold_bit(stop);
        hold_bit(1'b1);
        if (expect_kept) begin
            e.data = val[7:0];
            e.bit8 = nine ? val[8] : 1'b0;
            e.ferr = ~stop;
            sb_q.push_back(e);
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    // monitor: compares the head word against the scoreboard, then pops it
    task automatic pop_check(input string req);
        exp_t e;
        @(negedge clk);
        if (sb_q.size() == 0) begin
            check(1'b0, req, "scoreboard empty", 0, 1);
        end else begin
            e = sb_q.pop_front();
            check(irq === 1'b1, req, "irq with data", int'(irq), 1);
            check(rd_data === e.data, req, "data", int'(rd_data), int'(e.data));
            check(rd_bit8 === e.bit8, req, "ninth bit", int'(rd_bit8), int'(e.bit8));
            check(ferr === e.ferr, req, "framing flag", int'(ferr), int'(e.ferr));
        end
        pulse_rd();
    endtask

    task automatic expect_irq(input logic v, input string req, input string what);
        @(negedge clk);
        check(irq === v, req, what, int'(irq), int'(v));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R7: reset state
        check(irq === 1'b0, "R7", "irq after reset", int'(irq), 0);
        check(ovr === 1'b0, "R7", "overrun after reset", int'(ovr), 0);
        check(wake_en === 1'b0, "R10", "wake after reset", int'(wake_en), 0);

        // R2 / R11: 8-bit frames, LSB first, mid-bit sampling
        send_frame(9'h0A5, 1'b1, 1);
        pop_check("R2");
        expect_irq(1'b0, "R7", "irq cleared by read");
        send_frame(9'h03C, 1'b1, 1);
        pop_check("R11");

        // R3: 9-bit mode
        nine = 1'b1;
        send_frame(9'h1C3, 1'b1, 1);
        pop_check("R3");
        send_frame(9'h07E, 1'b1, 1);
        pop_check("R3");
        nine = 1'b0;

        // R4: two words kept in arrival order
        send_frame(9'h011, 1'b1, 1);
        send_frame(9'h022, 1'b1, 1);
        pop_check("R4");
        expect_irq(1'b1, "R4", "second word still pending");
        pop_check("R4");
        expect_irq(1'b0, "R4", "buffer drained");

        // R6: stop bit low gives framing error, next good word clears it
        send_frame(9'h0F0, 1'b0, 1);
        pop_check("R6");
        send_frame(9'h00F, 1'b1, 1);
        pop_check("R6");

        // R8: short low pulse is rejected
        @(negedge clk); rx = 1'b0;
        repeat (3 * TPB) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        expect_irq(1'b0, "R8", "glitch produced no word");
        send_frame(9'h081, 1'b1, 1);
        pop_check("R8");

        // R1: disabled receiver accepts nothing
        rx_en = 1'b0;
        send_frame(9'h055, 1'b1, 0);
        expect_irq(1'b0, "R1", "no word while disabled");
        rx_en = 1'b1;
        send_frame(9'h066, 1'b1, 1);
        pop_check("R1");

        // R5: third word overruns, later words ignored, disable clears flag
        send_frame(9'h031, 1'b1, 1);
        send_frame(9'h032, 1'b1, 1);
        send_frame(9'h033, 1'b1, 0);
        @(negedge clk);
        check(ovr === 1'b1, "R5", "overrun set", int'(ovr), 1);
        send_frame(9'h034, 1'b1, 0);
        pop_check("R5");
        pop_check("R5");
        expect_irq(1'b0, "R5", "words after overrun discarded");
        @(negedge clk);
        check(ovr === 1'b1, "R5", "overrun holds", int'(ovr), 1);
        rx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(ovr === 1'b0, "R5", "overrun cleared by disable", int'(ovr), 0);
        rx_en = 1'b1;
        send_frame(9'h035, 1'b1, 1);
        pop_check("R5");

        // R9 / R10: break wakes, mode self-clears, read clears irq
        @(negedge clk); wake_set = 1'b1;
        @(negedge clk); wake_set = 1'b0;
        check(wake_en === 1'b1, "R10", "wake mode set", int'(wake_en), 1);
        @(negedge clk); rx = 1'b0;
        repeat (10) @(negedge clk);
        check(irq === 1'b1, "R9", "irq on wake edge", int'(irq), 1);
        repeat (12 * BITCLK) @(negedge clk);
        check(wake_en === 1'b1, "R10", "wake mode kept while low", int'(wake_en), 1);
        rx = 1'b1;
        repeat (10) @(negedge clk);
        check(wake_en === 1'b0, "R10", "wake mode self-cleared", int'(wake_en), 0);
        check(irq === 1'b1, "R9", "irq held until read", int'(irq), 1);
        pulse_rd();
        expect_irq(1'b0, "R9", "read clears wake irq, no data");
        repeat (BITCLK) @(negedge clk);
        send_frame(9'h0C6, 1'b1, 1);
        pop_check("R10");

        // R9: a frame sent in wake mode yields only the wake event
        @(negedge clk); wake_set = 1'b1;
        @(negedge clk); wake_set = 1'b0;
        send_frame(9'h000, 1'b1, 0);
        expect_irq(1'b1, "R9", "wake irq from frame");
        pulse_rd();
        expect_irq(1'b0, "R9", "no word buffered in wake mode");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule